// File: doc/BRIEF.md
# System Clock Enable Divider with Interrupt Switchback

This block turns every oscillator cycle into a candidate for a one-cycle system clock enable and decides which candidates pass. The ratio comes from a small setting: a two-bit divide code and a half-speed flag. The divide code picks unity rate, a slow rate of one enable per `SLOW_DIV` cycles (1024 by default), or a fast group. Within the fast group, the flag picks between unity rate and one enable per `HALF_DIV` cycles. Software writes the setting through a one-cycle write strobe and reads it back on a parallel output. A switchback-enable bit sits in the same word.

Two hardware rules limit software. First, while the serial busy input is high, any write that would change the divide code is dropped as a whole, so software must read back the setting to confirm a change. Second, when switchback is armed and the slow rate is in force, any pulse on the external interrupt event inputs returns the divide code to unity rate. This return wins over a write in the same cycle that asks for the slow rate.

The setting register changes on the clock edge after the write. The counter that spaces the enables picks up a new ratio only when an enable is issued, so an interval in progress is never cut short. The asynchronous reset input is released to the logic through a synchroniser.

Top module: `sysclk_divider`

## Requirements
- R1: While reset is active, and for the synchroniser delay after it, `clk_en` is low and `rd_data` reads 4'b0010 (switchback off, flag 0, unity code). Afterwards `clk_en` is high on every cycle.
- R2: Divide code 2'b10 in `rd_data[1:0]` gives an enable on every cycle. The otherwise unused code 2'b01 does the same.
- R3: Divide code 2'b11 gives exactly one enable every `SLOW_DIV` cycles. The default is 1024.
- R4: Divide code 2'b00 with flag `rd_data[2]` = 0 gives one enable every `HALF_DIV` cycles (default 2). With the flag set to 1 it gives an enable on every cycle.
- R5: The interval after each enable follows the setting held in the cycle of that enable. A ratio change never shortens the interval already running.
- R6: While `ser_busy` is high, a write whose `wr_data[1:0]` differs from the current divide code is ignored, and `rd_data` does not change.
- R7: While `ser_busy` is high, a write that keeps the divide code is accepted, and `rd_data` takes `wr_data` on the next cycle.
- R8: If `rd_data[3]` (switchback armed) is 1, the code is 2'b11, and any bit of `ext_evt` is high, the code reads 2'b10 on the next cycle. The flag and switchback bits keep their values.
- R9: With switchback off, `ext_evt` has no effect on the setting or on the enable rate.
- R10: If switchback is armed and an `ext_evt` pulse arrives in the same cycle as a write of code 2'b11, the setting does not end up at code 2'b11.
- R11: With switchback armed and a code other than 2'b11, `ext_evt` leaves the setting unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the setting |
| wr_data | input | 4 | Setting to write: [3] switchback enable, [2] half-speed flag, [1:0] divide code |
| ext_evt | input | N_EXT | Events from enabled external interrupts, active high |
| ser_busy | input | 1 | High while a serial port is sending or receiving |
| clk_en | output | 1 | System clock enable, one cycle wide |
| rd_data | output | 4 | Current setting, same layout as `wr_data` |

## Verification
The checker assumes that `wr_en`, `wr_data`, `ext_evt` and `ser_busy` are synchronous to `clk` and stable over each whole cycle. It also assumes a write strobe lasts one cycle and carries its data in that same cycle. The bench changes every input only on the falling edge and reads the outputs there as well. Interrupt pulses and write strobes are one cycle wide, and reset is held for several cycles before release. The switchback checks leave out cycles in which a competing write that does not select the slow code is present, because such a write legitimately decides the outcome.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;

  typedef struct packed {
    logic       swb;
    logic       fx;
    logic [1:0] cd;
  } div_cfg_t;

  localparam logic [1:0] CD_FAST  = 2'b00;
  localparam logic [1:0] CD_UNITY = 2'b10;
  localparam logic [1:0] CD_SLOW  = 2'b11;

  localparam div_cfg_t CFG_RESET = '{swb: 1'b0, fx: 1'b0, cd: CD_UNITY};

endpackage

// File: rtl/sysclk_div_rst_sync.sv
module sysclk_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysclk_div_pkg::*;
#(
  parameter int N_EXT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  div_cfg_t         wr_cfg,
  input  logic [N_EXT-1:0] ext_evt,
  input  logic             ser_busy,
  output div_cfg_t         cfg
);
  div_cfg_t cfg_q, cfg_nxt;
  logic     accept, sb_fire, cfg_ld;

  // A write is refused while serial traffic is active, but only when it moves the code.
  always_comb begin
    accept  = wr_en && !(ser_busy && (wr_cfg.cd != cfg_q.cd));
    cfg_nxt = accept ? wr_cfg : cfg_q;
    // The switchback is tested on the outcome, so it also overrides a write that asks for the slow code.
    sb_fire = cfg_q.swb && (|ext_evt) && (cfg_nxt.cd == CD_SLOW);
    if (sb_fire) cfg_nxt.cd = CD_UNITY;
    cfg_ld  = accept || sb_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_ld) cfg_q <= cfg_nxt;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/sysclk_div_tick.sv
module sysclk_div_tick
  import sysclk_div_pkg::*;
#(
  parameter int SLOW_DIV = 1024,
  parameter int HALF_DIV = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_cfg_t cfg,
  output logic     tick
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] SLOW_M1 = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_nxt, reload;
  logic          run_q;

  always_comb begin
    case (cfg.cd)
      CD_SLOW: reload = SLOW_M1;
      CD_FAST: reload = cfg.fx ? '0 : HALF_M1;
      default: reload = '0;
    endcase
  end

  assign tick = run_q && (cnt_q == '0);

  always_comb begin
    if (!run_q)            cnt_nxt = '0;
    else if (cnt_q == '0)  cnt_nxt = reload;
    else                   cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_div_pkg::*;
#(
  parameter int N_EXT       = 6,
  parameter int SLOW_DIV    = 1024,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_data,
  input  logic [N_EXT-1:0] ext_evt,
  input  logic             ser_busy,
  output logic             clk_en,
  output logic [3:0]       rd_data
);
  logic     rst_n;
  div_cfg_t cfg;

  sysclk_div_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  sysclk_div_ctrl #(.N_EXT(N_EXT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(div_cfg_t'(wr_data)),
    .ext_evt(ext_evt), .ser_busy(ser_busy), .cfg(cfg)
  );

  sysclk_div_tick #(.SLOW_DIV(SLOW_DIV), .HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(clk_en)
  );

  assign rd_data = cfg;
endmodule

// File: rtl/sysclk_divider_chk.sv
module sysclk_divider_chk #(
  parameter int N_EXT    = 6,
  parameter int SLOW_DIV = 1024
) (
  input logic             clk,
  input logic             arst_n,
  input logic             wr_en,
  input logic [3:0]       wr_data,
  input logic [N_EXT-1:0] ext_evt,
  input logic             ser_busy,
  input logic             clk_en,
  input logic [3:0]       rd_data
);
  localparam int GW = $clog2(SLOW_DIV) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                     gap_q <= '0;
    else if (clk_en)                 gap_q <= '0;
    else if (gap_q != {GW{1'b1}})    gap_q <= gap_q + 1'b1;
  end

  logic sb_case;
  assign sb_case = rd_data[3] && (rd_data[1:0] == 2'b11) && (|ext_evt);

  assert_gap_bounded_R3: assert property (@(posedge clk) disable iff (!arst_n)
    32'(gap_q) < SLOW_DIV);

  assert_unity_every_cycle_R2: assert property (@(posedge clk) disable iff (!arst_n)
    clk_en && (rd_data[1] ^ rd_data[0]) |=> clk_en);

  assert_busy_refuse_R6: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en && ser_busy && (wr_data[1:0] != rd_data[1:0]) && !sb_case |=> $stable(rd_data));

  assert_switchback_R8: assert property (@(posedge clk) disable iff (!arst_n)
    sb_case && !wr_en |=> rd_data[1:0] == 2'b10);

  assert_evt_ignored_R9: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_data[3] && !wr_en |=> $stable(rd_data));

  assert_sb_priority_R10: assert property (@(posedge clk) disable iff (!arst_n)
    rd_data[3] && (|ext_evt) && wr_en && (wr_data[1:0] == 2'b11) |=> rd_data[1:0] != 2'b11);
endmodule

bind sysclk_divider sysclk_divider_chk #(.N_EXT(N_EXT), .SLOW_DIV(SLOW_DIV)) u_chk (.*);

// File: tb/sim_sysclk_divider.sv
`timescale 1ns/1ps
module sim_sysclk_divider;
  localparam int N_EXT = 6;

  logic             clk = 1'b0;
  logic             arst_n;
  logic             wr_en;
  logic [3:0]       wr_data;
  logic [N_EXT-1:0] ext_evt;
  logic             ser_busy;
  logic             clk_en;
  logic [3:0]       rd_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sysclk_divider u0 (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_evt(ext_evt), .ser_busy(ser_busy), .clk_en(clk_en), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [N_EXT-1:0] e);
    ext_evt = e;
    @(negedge clk);
    ext_evt = '0;
  endtask

  task automatic sync_en();
    int n = 0;
    while (!clk_en && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic gap_now(output int g);
    int n = 0;
    do begin @(negedge clk); n++; end while (!clk_en && n < 3000);
    g = n;
  endtask

  task automatic t_reset_R1();
    int g;
    arst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(rd_data == 4'b0010, "R1 reset setting", rd_data, 4'b0010);
    chk(clk_en == 1'b0, "R1 enable low in reset", clk_en, 0);
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rd_data == 4'b0010, "R1 setting after release", rd_data, 4'b0010);
    chk(clk_en == 1'b1, "R1 enable after release", clk_en, 1);
    gap_now(g); chk(g == 1, "R1 unity gap", g, 1);
  endtask

  task automatic t_reserved_R2();
    int g;
    write_cfg(4'b0001);
    sync_en(); gap_now(g); gap_now(g);
    chk(g == 1, "R2 code 01 gap", g, 1);
    write_cfg(4'b0010);
    sync_en(); gap_now(g); gap_now(g);
    chk(g == 1, "R2 code 10 gap", g, 1);
  endtask

  task automatic t_fast_R4();
    int g;
    write_cfg(4'b0000);
    sync_en(); gap_now(g); gap_now(g);
    chk(g == 2, "R4 half gap", g, 2);
    write_cfg(4'b0100);
    sync_en(); gap_now(g); gap_now(g);
    chk(g == 1, "R4 flag set gap", g, 1);
    write_cfg(4'b0010);
  endtask

  task automatic t_slow_R3();
    int g;
    write_cfg(4'b0011);
    sync_en(); gap_now(g); gap_now(g);
    chk(g == 1024, "R3 slow gap", g, 1024);
    gap_now(g);
    chk(g == 1024, "R3 slow gap repeat", g, 1024);
  endtask

  task automatic t_boundary_R5();
    int g;
    // slow -> unity written in the cycle of an enable: current interval stays full
    sync_en();
    write_cfg(4'b0010);
    g = 1;
    while (!clk_en && g < 3000) begin @(negedge clk); g++; end
    chk(g == 1024, "R5 slow interval kept", g, 1024);
    gap_now(g); chk(g == 1, "R5 unity after boundary", g, 1);
    // unity -> slow written at an enable: one more unity interval, then slow
    sync_en();
    write_cfg(4'b0011);
    chk(clk_en == 1'b1, "R5 unity interval kept", clk_en, 1);
    gap_now(g); chk(g == 1024, "R5 slow after boundary", g, 1024);
  endtask

  task automatic t_busy_R6_R7();
    ser_busy = 1'b1;
    write_cfg(4'b0010);
    chk(rd_data == 4'b0011, "R6 busy code change refused", rd_data, 4'b0011);
    write_cfg(4'b1111);
    chk(rd_data == 4'b1111, "R7 busy same code accepted", rd_data, 4'b1111);
    ser_busy = 1'b0;
  endtask

  task automatic t_switchback_R8_R10_R11();
    int g;
    pulse_evt(6'b000100);
    chk(rd_data == 4'b1110, "R8 switchback", rd_data, 4'b1110);
    sync_en(); gap_now(g);
    chk(g == 1, "R8 unity rate after switchback", g, 1);
    wr_en = 1'b1; wr_data = 4'b1011; ext_evt = 6'b100000;
    @(negedge clk);
    wr_en = 1'b0; ext_evt = '0;
    chk(rd_data == 4'b1010, "R10 switchback beats write", rd_data, 4'b1010);
    pulse_evt(6'b000001);
    chk(rd_data == 4'b1010, "R11 no effect off slow code", rd_data, 4'b1010);
  endtask

  task automatic t_disabled_R9();
    int g;
    write_cfg(4'b0011);
    sync_en();
    pulse_evt(6'b010000);
    chk(rd_data == 4'b0011, "R9 event ignored", rd_data, 4'b0011);
    sync_en(); gap_now(g);
    chk(g == 1024, "R9 slow rate kept", g, 1024);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ext_evt = '0; ser_busy = 1'b0;
    @(negedge clk);
    t_reset_R1();
    t_reserved_R2();
    t_fast_R4();
    t_slow_R3();
    t_boundary_R5();
    t_busy_R6_R7();
    t_switchback_R8_R10_R11();
    t_disabled_R9();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule